// File: doc/BRIEF.md
# Transmit Queue DMA Engine

This block is the transmit half of a network controller's DMA. Software places a ring of two-word descriptors in memory, programs the ring base, and then writes the control register with the start bit and the transmit-enable bit set together. The engine walks the ring. For each descriptor it reads the buffer address and the status word, fetches the buffer one 32-bit word at a time over a read port, and presents the bytes on a valid/ready byte stream. When a buffer has been sent, the engine writes the descriptor's status word back with its used flag set. The walk stops after a buffer whose last flag is set, and the next start resumes from the descriptor that follows.

Faults go into a transmit status register, and software clears its bits by writing ones to them. A bus error on any fetch and a stalled fetch that starves the sink both abort the frame. A used descriptor reached in the middle of a frame is also reported. Framing, padding, CRC and the line interface belong to blocks further downstream.

Stream rules: once `tx_valid` is high, `tx_data` and `tx_last` hold their values and `tx_valid` stays high until `tx_ready` accepts the byte. The only exception is that software clears transmit enable. The read port has one request in flight at most. A request holds its address until `mem_rd_ready` accepts it, and memory answers each accepted request with exactly one `mem_rd_rvalid` pulse, in order. A write-back holds steady until `mem_wr_ready`.

Top module: `txq_dma`

## Requirements
- R1: After reset the control and status registers read zero, the ring base reads zero, `tx_busy` is low, and no read, write or stream transfer is requested.
- R2: A write of the control register (select 0) with bit 9 and bit 3 both set starts the walk at the current descriptor. The engine reads the buffer address at the descriptor address and then the status word at that address plus 4, and only after that does it fetch the buffer. In the status word, bits 13:0 give the buffer length in bytes, bit 15 means last buffer of frame, bit 30 means wrap and bit 31 means used. Buffer addresses are word aligned.
- R3: The bytes of a buffer go out in ascending address order, lowest byte lane of each word first, exactly length bytes in all. `tx_last` is high only on the final byte of a buffer whose last flag is set.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R5: After a buffer has been sent, the engine writes the descriptor's status word, with bit 31 set, to the descriptor address plus 4.
- R6: After a buffer without the last flag, the walk continues at the descriptor 8 bytes on. A descriptor with the wrap flag sends the next step back to the ring base. The walk stops after a buffer that has the last flag.
- R7: When the status word fetched has bit 31 set, the engine stops without sending. It sets status bit 4 (buffers exhausted) only if a frame was in progress.
- R8: An error response on any fetch sets status bit 8, aborts the frame with no further bytes, and leaves the engine idle.
- R9: Once a frame has sent a byte, if the sink stays ready for UNDERRUN_LIMIT cycles in a row with no byte offered, the engine sets status bit 6 and aborts the frame.
- R10: Writing the status register (select 1) clears exactly the bits written as 1, and leaves the other bits as they were.
- R11: While control bit 3 is clear the engine issues no request and offers no byte. A start write without bit 3 does nothing. A walk that was paused resumes when bit 3 is set again.
- R12: A start write while the engine is busy has no effect on the walk in progress.
- R13: Writing the ring base (select 2) while the engine is idle makes that address the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 ring base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | AW | Read byte address (word aligned) |
| mem_rd_rvalid | input | 1 | Read response valid |
| mem_rd_rdata | input | 32 | Read response data |
| mem_rd_rerr | input | 1 | Read response carries a bus error |
| mem_wr_valid | output | 1 | Status write-back valid |
| mem_wr_ready | input | 1 | Write-back accepted |
| mem_wr_addr | output | AW | Write-back address |
| mem_wr_data | output | 32 | Write-back data |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Byte |
| tx_last | output | 1 | Final byte of frame |
| tx_busy | output | 1 | Engine is walking the ring |

## Verification
Every cycle, the assertions hold the stream and read-request stability rules. They also check that nothing moves while transmit is disabled, that no request is raised outside a walk, that a last byte is followed by a gap, and that a bus error leaves the engine idle with its flag set. Byte order, descriptor chaining and wrap, the write-back contents, the conditional exhausted flag, underrun timing, write-one-to-clear and the ignored restart depend on memory contents and sequences. Only the bench's directed scenarios can show those.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int CTL_RXEN = 2;
  localparam int CTL_TXEN = 3;
  localparam int CTL_GO   = 9;
  localparam int ST_EXH   = 4;
  localparam int ST_URUN  = 6;
  localparam int ST_BUS   = 8;
  localparam int D_LAST   = 15;
  localparam int D_WRAP   = 30;
  localparam int D_USED   = 31;
  localparam int LEN_W    = 14;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_A_REQ, S_A_WAIT, S_S_REQ, S_S_WAIT,
    S_D_REQ, S_D_WAIT, S_SEND, S_WB
  } txq_state_e;
endpackage

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          tx_en,
  output logic          go,
  output logic [AW-1:0] base,
  output logic          base_ld,
  input  logic          set_bus,
  input  logic          set_urun,
  input  logic          set_exh,
  output logic [31:0]   stat_word
);
  logic          rxen_q, txen_q;
  logic [2:0]    flags_q;   // {bus, urun, exh}
  logic [AW-1:0] base_q;
  logic [2:0]    clr, set;
  logic          unused_bits;

  assign unused_bits = ^{wdata[31:10], wdata[8:7], wdata[5], wdata[1:0]};

  assign go    = we && sel == SEL_CTRL && wdata[CTL_GO] && wdata[CTL_TXEN];
  assign tx_en = txen_q;
  assign base  = base_q;
  assign clr   = (we && sel == SEL_STAT) ? {wdata[ST_BUS], wdata[ST_URUN], wdata[ST_EXH]} : 3'b000;
  assign set   = {set_bus, set_urun, set_exh};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
      flags_q <= '0;
      base_q  <= '0;
      base_ld <= 1'b0;
    end else begin
      base_ld <= 1'b0;
      if (we && sel == SEL_CTRL) begin
        rxen_q <= wdata[CTL_RXEN];
        txen_q <= wdata[CTL_TXEN];
      end
      if (we && sel == SEL_BASE) begin
        base_q  <= {wdata[AW-1:3], 3'b000};
        base_ld <= 1'b1;
      end
      flags_q <= (flags_q & ~clr) | set;
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[ST_BUS]   = flags_q[2];
    stat_word[ST_URUN]  = flags_q[1];
    stat_word[ST_EXH]   = flags_q[0];
    rdata = '0;
    case (sel)
      SEL_CTRL: begin
        rdata[CTL_RXEN] = rxen_q;
        rdata[CTL_TXEN] = txen_q;
      end
      SEL_STAT: rdata = stat_word;
      SEL_BASE: rdata = 32'(base_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/txq_unpack.sv
module txq_unpack #(
  parameter int BYTES = 4,
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [8*BYTES-1:0] load_word,
  input  logic [CW-1:0]    load_cnt,
  input  logic             take,
  output logic [7:0]       byte_o,
  output logic [CW-1:0]    cnt_o
);
  logic [8*BYTES-1:0] sh_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= load_word;
      cnt_q <= load_cnt;
    end else if (take && cnt_q != '0) begin
      sh_q  <= sh_q >> 8;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign byte_o = sh_q[7:0];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/txq_engine.sv
module txq_engine
  import txq_pkg::*;
#(
  parameter int AW = 32,
  parameter int UNDERRUN_LIMIT = 16,
  localparam int UR_W = $clog2(UNDERRUN_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          go,
  input  logic [AW-1:0] base,
  input  logic          base_ld,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_rvalid,
  input  logic [31:0]   mem_rd_rdata,
  input  logic          mem_rd_rerr,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          tx_busy,
  output logic          unp_load,
  output logic [2:0]    unp_cnt_ld,
  output logic          unp_take,
  input  logic [2:0]    unp_cnt,
  output logic          err_bus,
  output logic          err_urun,
  output logic          err_exh
);
  txq_state_e       st_q;
  logic [AW-1:0]    cur_q, buf_q;
  logic [LEN_W-1:0] rem_q;
  logic [31:0]      dstat_q;
  logic             in_frame_q, sent_q, drop_q;
  logic [UR_W-1:0]  ur_q;
  logic             rd_fire, wr_fire, tx_fire, waiting, rsp_ok, ur_tick, abort;

  assign waiting  = st_q == S_A_WAIT || st_q == S_S_WAIT || st_q == S_D_WAIT;
  assign mem_rd_valid = tx_en && !drop_q &&
                        (st_q == S_A_REQ || st_q == S_S_REQ || st_q == S_D_REQ);
  assign rd_fire  = mem_rd_valid && mem_rd_ready;
  assign mem_wr_valid = tx_en && st_q == S_WB;
  assign wr_fire  = mem_wr_valid && mem_wr_ready;
  assign mem_wr_addr  = cur_q + AW'(4);
  assign mem_wr_data  = dstat_q | (32'd1 << D_USED);
  assign tx_valid = tx_en && st_q == S_SEND;
  assign tx_fire  = tx_valid && tx_ready;
  assign tx_last  = dstat_q[D_LAST] && rem_q == LEN_W'(1);
  assign tx_busy  = st_q != S_IDLE;

  assign rsp_ok   = waiting && mem_rd_rvalid && !mem_rd_rerr;
  assign err_bus  = waiting && mem_rd_rvalid && mem_rd_rerr;
  assign ur_tick  = sent_q && tx_en && tx_ready && !tx_valid && st_q != S_IDLE;
  assign err_urun = ur_tick && ur_q == UR_W'(UNDERRUN_LIMIT - 1);
  assign err_exh  = rsp_ok && st_q == S_S_WAIT && mem_rd_rdata[D_USED] && in_frame_q;
  assign abort    = err_bus || err_urun;

  assign unp_load   = rsp_ok && st_q == S_D_WAIT;
  assign unp_cnt_ld = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign unp_take   = tx_fire;

  always_comb begin
    case (st_q)
      S_A_REQ: mem_rd_addr = cur_q;
      S_S_REQ: mem_rd_addr = cur_q + AW'(4);
      default: mem_rd_addr = buf_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cur_q      <= '0;
      buf_q      <= '0;
      rem_q      <= '0;
      dstat_q    <= '0;
      in_frame_q <= 1'b0;
      sent_q     <= 1'b0;
      drop_q     <= 1'b0;
      ur_q       <= '0;
    end else begin
      if (!sent_q || tx_fire || st_q == S_IDLE) ur_q <= '0;
      else if (ur_tick) ur_q <= ur_q + UR_W'(1);

      if (drop_q && mem_rd_rvalid) drop_q <= 1'b0;
      if (st_q == S_IDLE && base_ld) cur_q <= base;

      case (st_q)
        S_IDLE:   if (go) st_q <= S_A_REQ;
        S_A_REQ:  if (rd_fire) st_q <= S_A_WAIT;
        S_A_WAIT: if (rsp_ok) begin
          buf_q <= {mem_rd_rdata[AW-1:2], 2'b00};
          st_q  <= S_S_REQ;
        end
        S_S_REQ:  if (rd_fire) st_q <= S_S_WAIT;
        S_S_WAIT: if (rsp_ok) begin
          if (mem_rd_rdata[D_USED]) begin
            in_frame_q <= 1'b0;
            sent_q     <= 1'b0;
            st_q       <= S_IDLE;
          end else begin
            dstat_q    <= mem_rd_rdata;
            rem_q      <= mem_rd_rdata[LEN_W-1:0];
            in_frame_q <= 1'b1;
            st_q <= (mem_rd_rdata[LEN_W-1:0] == '0) ? S_WB : S_D_REQ;
          end
        end
        S_D_REQ:  if (rd_fire) st_q <= S_D_WAIT;
        S_D_WAIT: if (rsp_ok) begin
          buf_q <= buf_q + AW'(4);
          st_q  <= S_SEND;
        end
        S_SEND:   if (tx_fire) begin
          rem_q  <= rem_q - LEN_W'(1);
          sent_q <= 1'b1;
          if (unp_cnt == 3'd1) st_q <= (rem_q == LEN_W'(1)) ? S_WB : S_D_REQ;
        end
        S_WB:     if (wr_fire) begin
          cur_q <= dstat_q[D_WRAP] ? base : cur_q + AW'(8);
          if (dstat_q[D_LAST]) begin
            in_frame_q <= 1'b0;
            sent_q     <= 1'b0;
            st_q       <= S_IDLE;
          end else begin
            st_q <= S_A_REQ;
          end
        end
        default:  st_q <= S_IDLE;
      endcase

      if (abort) begin
        st_q       <= S_IDLE;
        in_frame_q <= 1'b0;
        sent_q     <= 1'b0;
        if (waiting && !mem_rd_rvalid) drop_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txq_dma.sv
module txq_dma
  import txq_pkg::*;
#(
  parameter int AW = 32,
  parameter int UNDERRUN_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_rvalid,
  input  logic [31:0]   mem_rd_rdata,
  input  logic          mem_rd_rerr,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_busy
);
  logic          tx_en, go, base_ld, err_bus, err_urun, err_exh;
  logic [AW-1:0] base;
  logic [31:0]   stat_word;
  logic          unp_load, unp_take;
  logic [2:0]    unp_cnt_ld, unp_cnt;

  txq_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .tx_en(tx_en), .go(go), .base(base), .base_ld(base_ld),
    .set_bus(err_bus), .set_urun(err_urun), .set_exh(err_exh), .stat_word(stat_word)
  );

  txq_engine #(.AW(AW), .UNDERRUN_LIMIT(UNDERRUN_LIMIT)) u_engine (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .go(go), .base(base), .base_ld(base_ld),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata), .mem_rd_rerr(mem_rd_rerr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .tx_busy(tx_busy), .unp_load(unp_load), .unp_cnt_ld(unp_cnt_ld), .unp_take(unp_take),
    .unp_cnt(unp_cnt), .err_bus(err_bus), .err_urun(err_urun), .err_exh(err_exh)
  );

  txq_unpack #(.BYTES(4)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(unp_load), .load_word(mem_rd_rdata),
    .load_cnt(unp_cnt_ld), .take(unp_take), .byte_o(tx_data), .cnt_o(unp_cnt)
  );
endmodule

// File: rtl/txq_dma_chk.sv
module txq_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_rvalid,
  input logic          mem_rd_rerr,
  input logic          mem_wr_valid,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_busy,
  input logic          tx_en,
  input logic          bus_flag
);
  logic ctl_wr;
  assign ctl_wr = reg_we && reg_sel == 2'd0;

  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ctl_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R2
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready && !ctl_wr) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!mem_rd_valid && !mem_wr_valid && !tx_valid));

  // R1
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid || tx_valid) |-> tx_busy);

  // R3
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  // R8
  bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && mem_rd_rvalid && mem_rd_rerr) |=> (!tx_busy && bus_flag));
endmodule

bind txq_dma txq_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rerr(mem_rd_rerr), .mem_wr_valid(mem_wr_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .tx_busy(tx_busy), .tx_en(tx_en), .bus_flag(stat_word[8])
);

// File: tb/txq_dma_bench.sv
module txq_dma_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_rvalid = 1'b0, mem_rd_rerr = 1'b0;
  logic [31:0] mem_rd_rdata = '0;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        tx_valid, tx_last, tx_busy;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;

  txq_dma u_txq_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
    .mem_rd_rerr(mem_rd_rerr), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(1'b1),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_busy(tx_busy)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // memory model: descriptors below 0x100, computed pattern above, errors from 0x3C0
  logic [31:0] desc_mem [0:63];
  logic        bk_we = 1'b0;
  logic [31:0] bk_addr = '0, bk_data = '0;
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  int          dly = 0;
  int          slow_addr = -1;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  function automatic logic [31:0] pat_word(int a);
    return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
  endfunction

  assign mem_rd_ready = !pend;

  always @(posedge clk) begin
    mem_rd_rvalid <= 1'b0;
    mem_rd_rerr   <= 1'b0;
    if (bk_we) desc_mem[bk_addr[7:2]] <= bk_data;
    if (mem_wr_valid && mem_wr_addr < 32'h100) desc_mem[mem_wr_addr[7:2]] <= mem_wr_data;
    if (pend) begin
      if (dly == 0) begin
        mem_rd_rvalid <= 1'b1;
        mem_rd_rerr   <= (paddr >= 32'h3C0);
        mem_rd_rdata  <= (paddr < 32'h100) ? desc_mem[paddr[7:2]] : pat_word(int'(paddr));
        pend <= 1'b0;
      end else dly <= dly - 1;
    end else if (mem_rd_valid) begin
      pend  <= 1'b1;
      paddr <= mem_rd_addr;
      dly   <= (int'(mem_rd_addr) == slow_addr) ? 40 : 0;
    end
  end

  // sink ready pattern
  bit bp_mode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready = bp_mode ? ((cyc % 3) != 2) : 1'b1;
  end

  // monitor away from the edge
  logic [7:0] rx_byte [0:255];
  bit         rx_lastf [0:255];
  logic [31:0] rd_log [0:255];
  int rx_n = 0, wr_n = 0, rd_n = 0;
  logic [31:0] wr_addr_l = '0, wr_data_l = '0;
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      rx_byte[rx_n % 256]  <= tx_data;
      rx_lastf[rx_n % 256] <= tx_last;
      rx_n <= rx_n + 1;
    end
    if (rst_n && mem_wr_valid) begin
      wr_n <= wr_n + 1;
      wr_addr_l <= mem_wr_addr;
      wr_data_l <= mem_wr_data;
    end
    if (rst_n && mem_rd_valid && mem_rd_ready) begin
      rd_log[rd_n % 256] <= mem_rd_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(posedge clk); #1;
    bk_we = 1'b1; bk_addr = a; bk_data = d;
    @(posedge clk); #1;
    bk_we = 1'b0;
  endtask

  function automatic logic [31:0] dstat(int len, bit last, bit wrap, bit used);
    return 32'(len) | (32'(last) << 15) | (32'(wrap) << 30) | (32'(used) << 31);
  endfunction

  task automatic set_desc(int a, int bufa, int len, bit last, bit wrap, bit used);
    poke(a, bufa);
    poke(a + 4, dstat(len, last, wrap, used));
  endtask

  task automatic wait_idle();
    int t = 0;
    cycles(3);
    while (tx_busy && t < 3000) begin
      @(posedge clk);
      t++;
    end
    #1;
    cycles(2);
  endtask

  task automatic check_bytes(string req, int first, int bufa, int len, bit with_last);
    int bad = 0, badl = 0;
    for (int i = 0; i < len; i++) begin
      if (rx_byte[(first + i) % 256] != pat(bufa + i)) bad++;
      if (rx_lastf[(first + i) % 256] != (with_last && i == len - 1)) badl++;
    end
    chk(bad == 0, req, "byte values", bad, 0);
    chk(badl == 0, req, "last marker", badl, 0);
  endtask

  task automatic start_tx();
    reg_write(2'd0, 32'h0000_0208);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(2'd0, d); chk(d == 0, "R1", "ctrl", d, 0);
    reg_read(2'd1, d); chk(d == 0, "R1", "status", d, 0);
    reg_read(2'd2, d); chk(d == 0, "R1", "base", d, 0);
    chk(!tx_busy && !tx_valid && !mem_rd_valid && !mem_wr_valid, "R1", "idle outputs",
        {tx_busy, tx_valid, mem_rd_valid, mem_wr_valid}, 0);
  endtask

  task automatic t_no_enable();
    int r0;
    set_desc(32'h00, 32'h100, 6, 1, 0, 0);
    reg_write(2'd2, 32'h0);
    r0 = rd_n;
    reg_write(2'd0, 32'h0000_0200);
    cycles(10);
    chk(rd_n == r0 && !tx_busy, "R11", "start without enable", rd_n - r0, 0);
  endtask

  task automatic t_single();
    int r0 = rd_n, x0 = rx_n, w0 = wr_n;
    start_tx();
    wait_idle();
    chk(rd_log[r0 % 256] == 32'h0 && rd_log[(r0 + 1) % 256] == 32'h4, "R2", "descriptor reads",
        rd_log[(r0 + 1) % 256], 4);
    chk(rd_log[(r0 + 2) % 256] == 32'h100, "R2", "first buffer read", rd_log[(r0 + 2) % 256], 32'h100);
    chk(rx_n - x0 == 6, "R3", "byte count", rx_n - x0, 6);
    check_bytes("R3", x0, 32'h100, 6, 1);
    chk(wr_n - w0 == 1 && wr_addr_l == 32'h4, "R5", "writeback addr", wr_addr_l, 4);
    chk(wr_data_l == 32'h8000_8006, "R5", "writeback data", wr_data_l, 32'h8000_8006);
  endtask

  task automatic t_chain_wrap();
    int x0, r0;
    logic [31:0] d;
    set_desc(32'h40, 32'h140, 5, 0, 0, 0);
    set_desc(32'h48, 32'h180, 3, 1, 1, 0);
    reg_write(2'd2, 32'h40);
    x0 = rx_n;
    start_tx();
    wait_idle();
    chk(rx_n - x0 == 8, "R6", "chained byte count", rx_n - x0, 8);
    check_bytes("R6", x0, 32'h140, 5, 0);
    check_bytes("R6", x0 + 5, 32'h180, 3, 1);
    chk(wr_addr_l == 32'h4C, "R6", "second writeback", wr_addr_l, 32'h4C);
    // wrap returned to base; that descriptor is now used
    r0 = rd_n; x0 = rx_n;
    start_tx();
    wait_idle();
    chk(rd_log[r0 % 256] == 32'h40, "R6", "wrap to base", rd_log[r0 % 256], 32'h40);
    chk(rx_n == x0, "R7", "used stops, no bytes", rx_n - x0, 0);
    reg_read(2'd1, d);
    chk(d == 0, "R7", "no flag outside frame", d, 0);
  endtask

  task automatic t_exhaust();
    int x0, w0;
    logic [31:0] d;
    set_desc(32'h60, 32'h1C0, 4, 0, 0, 0);
    set_desc(32'h68, 32'h200, 4, 1, 0, 1);
    reg_write(2'd2, 32'h60);
    x0 = rx_n; w0 = wr_n;
    start_tx();
    wait_idle();
    chk(rx_n - x0 == 4 && wr_n - w0 == 1, "R7", "bytes before exhaust", rx_n - x0, 4);
    check_bytes("R7", x0, 32'h1C0, 4, 0);
    reg_read(2'd1, d);
    chk(d == 32'h10, "R7", "exhausted flag", d, 32'h10);
  endtask

  task automatic t_bus_err();
    int x0;
    logic [31:0] d;
    set_desc(32'h80, 32'h3C0, 4, 1, 0, 0);
    reg_write(2'd2, 32'h80);
    x0 = rx_n;
    start_tx();
    wait_idle();
    chk(rx_n == x0 && !tx_busy, "R8", "abort on bus error", rx_n - x0, 0);
    reg_read(2'd1, d);
    chk(d == 32'h110, "R8", "bus error flag", d, 32'h110);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    reg_write(2'd1, 32'h100);
    reg_read(2'd1, d);
    chk(d == 32'h10, "R10", "partial clear", d, 32'h10);
    reg_write(2'd1, 32'h10);
    reg_read(2'd1, d);
    chk(d == 32'h0, "R10", "full clear", d, 0);
  endtask

  task automatic t_underrun();
    int x0;
    logic [31:0] d;
    set_desc(32'hA0, 32'h200, 8, 1, 0, 0);
    reg_write(2'd2, 32'hA0);
    slow_addr = 32'h204;
    x0 = rx_n;
    start_tx();
    wait_idle();
    chk(rx_n - x0 == 4, "R9", "bytes before underrun", rx_n - x0, 4);
    reg_read(2'd1, d);
    chk(d == 32'h40, "R9", "underrun flag", d, 32'h40);
    cycles(50);
    slow_addr = -1;
    reg_write(2'd1, 32'h40);
  endtask

  task automatic t_backpressure();
    int x0;
    set_desc(32'hB0, 32'h300, 7, 1, 0, 0);
    reg_write(2'd2, 32'hB0);
    bp_mode = 1;
    x0 = rx_n;
    start_tx();
    wait_idle();
    bp_mode = 0;
    chk(rx_n - x0 == 7, "R4", "count under back-pressure", rx_n - x0, 7);
    check_bytes("R4", x0, 32'h300, 7, 1);
  endtask

  task automatic t_pause();
    int x0, n1, t;
    set_desc(32'hC0, 32'h240, 8, 1, 0, 0);
    reg_write(2'd2, 32'hC0);
    x0 = rx_n;
    start_tx();
    t = 0;
    while (rx_n - x0 < 2 && t < 200) begin @(negedge clk); t++; end
    reg_write(2'd0, 32'h0);
    n1 = rx_n;
    cycles(30);
    chk(rx_n == n1 && !tx_valid && !mem_rd_valid && tx_busy, "R11", "paused", rx_n - n1, 0);
    reg_write(2'd0, 32'h8);
    wait_idle();
    chk(rx_n - x0 == 8, "R11", "resumed count", rx_n - x0, 8);
    check_bytes("R11", x0, 32'h240, 8, 1);
  endtask

  task automatic t_restart_busy();
    int x0, t;
    set_desc(32'hE0, 32'h280, 12, 1, 0, 0);
    set_desc(32'hE8, 32'h2C0, 4, 1, 0, 0);
    reg_write(2'd2, 32'hE0);
    bp_mode = 1;
    x0 = rx_n;
    start_tx();
    t = 0;
    while (rx_n - x0 < 3 && t < 200) begin @(negedge clk); t++; end
    start_tx();
    wait_idle();
    cycles(20);
    bp_mode = 0;
    chk(rx_n - x0 == 12 && !tx_busy, "R12", "start while busy ignored", rx_n - x0, 12);
    check_bytes("R12", x0, 32'h280, 12, 1);
  endtask

  task automatic t_base_load();
    int r0;
    set_desc(32'hF0, 32'h100, 2, 1, 0, 0);
    reg_write(2'd2, 32'hF0);
    r0 = rd_n;
    start_tx();
    wait_idle();
    chk(rd_log[r0 % 256] == 32'hF0, "R13", "base becomes current", rd_log[r0 % 256], 32'hF0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) desc_mem[i] = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_no_enable();
    t_single();
    t_chain_wrap();
    t_exhaust();
    t_bus_err();
    t_w1c();
    t_underrun();
    t_backpressure();
    t_pause();
    t_restart_busy();
    t_base_load();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule